// File: doc/BRIEF.md
# Flash Firmware Header Scanner

This block walks a memory-mapped flash window looking for a firmware container image. After a start request it reads one 32-bit word at each stride boundary, starting at offset zero, and sorts the word into one of four classes: a container-image signature, a boot-loader signature, a configuration-store signature, or anything else. Only the first container signature met during a scan matters. For that header the scanner fetches two more words: the root-filesystem offset and the total image length. If the offset falls on a 512-byte sector boundary, the scanner publishes a partition slice described by a base and a size.

The scanner reaches the flash through a simple read port. A one-cycle request carries a byte address, and the flash side later answers with a one-cycle valid strobe and the data word. Only one read is ever outstanding. When the last stride position has been examined, the block raises a one-cycle done pulse. The slice outputs then hold their values until the next start request. A host starts a scan, waits for done, and reads the slice flag, base and size.

Top module: `fw_hdr_scan`

## Requirements
- R1: After reset, rd_req_o, done_o and slice_valid_o are 0, and slice_base_o and slice_size_o are 0.
- R2: A scan reads byte addresses 0, STRIDE_BYTES, 2*STRIDE_BYTES and so on, in ascending order, up to the last multiple below FLASH_BYTES. Each read address stays below FLASH_BYTES. After the last position is classified, done_o is high for exactly one cycle.
- R3: Each read is a single-cycle rd_req_o pulse. No new request is issued until rd_valid_i has answered the previous one, and an rd_valid_i that arrives while the block is idle has no effect.
- R4: A signature word equal to 32'h30524448 at offset H is a container header. The scanner then reads address H+24, which holds the filesystem offset F, and only after that reads address H+4, which holds the image length L.
- R5: Words equal to 32'h43464531 (boot loader) or 32'h48534C46 (configuration store), and all other non-container words, cause no further reads and no slice.
- R6: If F is not a multiple of 512 (F[8:0] != 0), the header is rejected: address H+4 is not read and slice_valid_o stays 0.
- R7: For an accepted header, slice_valid_o goes to 1 with slice_base_o = H+F and slice_size_o = L-F, both computed modulo 2^32.
- R8: Once one container header has been seen in a scan, every later container signature in that scan is ignored and triggers no field reads. This holds even when the first header was rejected.
- R9: A start_i that is accepted while idle clears slice_valid_o, slice_base_o and slice_size_o to 0 on the following cycle. A start_i asserted while a scan is running is ignored: the read sequence is unchanged and only one done_o pulse follows.
- R10: Between a done_o pulse and the next accepted start_i, slice_valid_o, slice_base_o and slice_size_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Byte address of the requested word |
| rd_valid_i | input | 1 | Read response strobe |
| rd_data_i | input | 32 | Read response word |
| slice_valid_o | output | 1 | A root-filesystem slice was found |
| slice_base_o | output | 32 | Slice base byte offset |
| slice_size_o | output | 32 | Slice size in bytes |
| done_o | output | 1 | One-cycle scan-complete pulse |

## Verification
The bench targets four corner cases:
- A rejected first header followed by a well-aligned second header. A scanner that latches "seen" only on acceptance would report the second header's slice.
- A header at the final stride position. An off-by-one step bound would either skip this position or read past the window.
- An image length smaller than the filesystem offset. This exposes a size path that saturates or sign-handles instead of wrapping.
- Stray response strobes while idle, and start pulses in mid-scan. These would restart the walk or spawn extra reads and extra done pulses.

Comparing every read address in order also catches a scanner that fetches the length before the offset, or fetches the length after a rejection.

// File: rtl/fw_scan_pkg.sv
package fw_scan_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SIG_REQ,
      ST_SIG_WAIT,
      ST_SIG_EVAL,
      ST_FS_REQ,
      ST_FS_WAIT,
      ST_LEN_REQ,
      ST_LEN_WAIT,
      ST_STEP,
      ST_DONE
   } scan_state_e;

   typedef enum logic [1:0] {
      CLS_OTHER,
      CLS_IMAGE,
      CLS_BOOT,
      CLS_CONFIG
   } sig_class_e;

endpackage

// File: rtl/fw_scan_walker.sv
module fw_scan_walker #(
   parameter int unsigned ADDR_W       = 24,
   parameter int unsigned FLASH_BYTES  = 32'h0002_0000,
   parameter int unsigned STRIDE_BYTES = 32'h0000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              advance_i,
   output logic [ADDR_W-1:0] offset_o,
   output logic              last_o
);

   localparam int unsigned STEPS = (FLASH_BYTES + STRIDE_BYTES - 1) / STRIDE_BYTES;
   localparam int unsigned IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam bit          POW2  = (STRIDE_BYTES & (STRIDE_BYTES - 1)) == 0;

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clear_i) begin
         idx_q <= '0;
      end else if (advance_i && !last_o) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign last_o = (idx_q == IDX_W'(STEPS - 1));

   generate
      if (POW2) begin : g_shift
         localparam int unsigned SH = $clog2(STRIDE_BYTES);
         assign offset_o = ADDR_W'(ADDR_W'(idx_q) << SH);
      end else begin : g_mult
         assign offset_o = ADDR_W'(32'(idx_q) * STRIDE_BYTES);
      end
   endgenerate

endmodule

// File: rtl/fw_scan_sigmatch.sv
module fw_scan_sigmatch
   import fw_scan_pkg::*;
#(
   parameter logic [WORD_W-1:0] SIG_IMAGE  = 32'h3052_4448,
   parameter logic [WORD_W-1:0] SIG_BOOT   = 32'h4346_4531,
   parameter logic [WORD_W-1:0] SIG_CONFIG = 32'h4853_4C46,
   parameter bit                PIPE       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              cls_vld_o,
   output sig_class_e        cls_o
);

   sig_class_e cls_d;

   always_comb begin
      if (word_i == SIG_IMAGE) begin
         cls_d = CLS_IMAGE;
      end else if (word_i == SIG_BOOT) begin
         cls_d = CLS_BOOT;
      end else if (word_i == SIG_CONFIG) begin
         cls_d = CLS_CONFIG;
      end else begin
         cls_d = CLS_OTHER;
      end
   end

   generate
      if (PIPE) begin : g_reg
         sig_class_e cls_q;
         logic       vld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cls_q <= CLS_OTHER;
               vld_q <= 1'b0;
            end else begin
               vld_q <= vld_i;
               if (vld_i) begin
                  cls_q <= cls_d;
               end
            end
         end
         assign cls_o     = cls_q;
         assign cls_vld_o = vld_q;
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign cls_o          = cls_d;
         assign cls_vld_o      = vld_i;
      end
   endgenerate

endmodule

// File: rtl/fw_scan_slice.sv
module fw_scan_slice
   import fw_scan_pkg::*;
#(
   parameter int unsigned ADDR_W       = 24,
   parameter int unsigned SECTOR_BYTES = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              hdr_load_i,
   input  logic [ADDR_W-1:0] hdr_ofs_i,
   input  logic              fs_load_i,
   input  logic              len_load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              seen_o,
   output logic [ADDR_W-1:0] hdr_ofs_o,
   output logic              fs_ok_o,
   output logic              slice_valid_o,
   output logic [WORD_W-1:0] slice_base_o,
   output logic [WORD_W-1:0] slice_size_o
);

   localparam bit SEC_POW2 = (SECTOR_BYTES & (SECTOR_BYTES - 1)) == 0;

   logic [WORD_W-1:0] fs_q;

   generate
      if (SEC_POW2) begin : g_mask
         assign fs_ok_o = (word_i & WORD_W'(SECTOR_BYTES - 1)) == '0;
      end else begin : g_mod
         assign fs_ok_o = (word_i % WORD_W'(SECTOR_BYTES)) == '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_o        <= 1'b0;
         hdr_ofs_o     <= '0;
         fs_q          <= '0;
         slice_valid_o <= 1'b0;
         slice_base_o  <= '0;
         slice_size_o  <= '0;
      end else if (clear_i) begin
         seen_o        <= 1'b0;
         hdr_ofs_o     <= '0;
         fs_q          <= '0;
         slice_valid_o <= 1'b0;
         slice_base_o  <= '0;
         slice_size_o  <= '0;
      end else begin
         if (hdr_load_i) begin
            seen_o    <= 1'b1;
            hdr_ofs_o <= hdr_ofs_i;
         end
         if (fs_load_i) begin
            fs_q <= word_i;
         end
         if (len_load_i) begin
            slice_valid_o <= 1'b1;
            slice_base_o  <= WORD_W'(hdr_ofs_o) + fs_q;
            slice_size_o  <= word_i - fs_q;
         end
      end
   end

endmodule

// File: rtl/fw_hdr_scan.sv
module fw_hdr_scan
   import fw_scan_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 24,
   parameter int unsigned       FLASH_BYTES  = 32'h0002_0000,
   parameter int unsigned       STRIDE_BYTES = 32'h0000_1000,
   parameter int unsigned       SECTOR_BYTES = 512,
   parameter int unsigned       FS_FIELD_AT  = 24,
   parameter int unsigned       LEN_FIELD_AT = 4,
   parameter logic [31:0]       SIG_IMAGE    = 32'h3052_4448,
   parameter logic [31:0]       SIG_BOOT     = 32'h4346_4531,
   parameter logic [31:0]       SIG_CONFIG   = 32'h4853_4C46,
   parameter bit                PIPE_MATCH   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [31:0]       rd_data_i,
   output logic              slice_valid_o,
   output logic [31:0]       slice_base_o,
   output logic [31:0]       slice_size_o,
   output logic              done_o
);

   localparam int unsigned FIELD_SPAN = (FS_FIELD_AT > LEN_FIELD_AT ? FS_FIELD_AT : LEN_FIELD_AT) + 4;

   generate
      if (FLASH_BYTES == 0) begin : g_bad_flash
         $error("flash window must be non-empty");
      end
      if (ADDR_W > 32 || (64'(1) << ADDR_W) < 64'(FLASH_BYTES)) begin : g_bad_addr
         $error("address width does not fit the flash window");
      end
      if (STRIDE_BYTES < FIELD_SPAN) begin : g_bad_stride
         $error("stride must cover the header fields");
      end
      if (SECTOR_BYTES == 0) begin : g_bad_sector
         $error("sector size must be non-zero");
      end
   endgenerate

   scan_state_e       st_q, st_d;
   logic              walk_clr, walk_adv, walk_last;
   logic [ADDR_W-1:0] walk_ofs;
   logic              sl_clr, hdr_ld, fs_ld, len_ld;
   logic              seen, fs_ok;
   logic [ADDR_W-1:0] hdr_ofs;
   logic              cls_vld;
   sig_class_e        cls;

   fw_scan_walker #(
      .ADDR_W       (ADDR_W),
      .FLASH_BYTES  (FLASH_BYTES),
      .STRIDE_BYTES (STRIDE_BYTES)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (walk_clr),
      .advance_i (walk_adv),
      .offset_o  (walk_ofs),
      .last_o    (walk_last)
   );

   fw_scan_sigmatch #(
      .SIG_IMAGE  (SIG_IMAGE),
      .SIG_BOOT   (SIG_BOOT),
      .SIG_CONFIG (SIG_CONFIG),
      .PIPE       (PIPE_MATCH)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld_i     (rd_valid_i && (st_q == ST_SIG_WAIT)),
      .word_i    (rd_data_i),
      .cls_vld_o (cls_vld),
      .cls_o     (cls)
   );

   fw_scan_slice #(
      .ADDR_W       (ADDR_W),
      .SECTOR_BYTES (SECTOR_BYTES)
   ) u_slice (
      .clk           (clk),
      .rst_n         (rst_n),
      .clear_i       (sl_clr),
      .hdr_load_i    (hdr_ld),
      .hdr_ofs_i     (walk_ofs),
      .fs_load_i     (fs_ld),
      .len_load_i    (len_ld),
      .word_i        (rd_data_i),
      .seen_o        (seen),
      .hdr_ofs_o     (hdr_ofs),
      .fs_ok_o       (fs_ok),
      .slice_valid_o (slice_valid_o),
      .slice_base_o  (slice_base_o),
      .slice_size_o  (slice_size_o)
   );

   always_comb begin
      st_d     = st_q;
      walk_clr = 1'b0;
      walk_adv = 1'b0;
      sl_clr   = 1'b0;
      hdr_ld   = 1'b0;
      fs_ld    = 1'b0;
      len_ld   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               walk_clr = 1'b1;
               sl_clr   = 1'b1;
               st_d     = ST_SIG_REQ;
            end
         end
         ST_SIG_REQ: st_d = ST_SIG_WAIT;
         ST_SIG_WAIT, ST_SIG_EVAL: begin
            if (cls_vld) begin
               if (cls == CLS_IMAGE && !seen) begin
                  hdr_ld = 1'b1;
                  st_d   = ST_FS_REQ;
               end else begin
                  st_d = ST_STEP;
               end
            end else if (st_q == ST_SIG_WAIT && rd_valid_i) begin
               st_d = ST_SIG_EVAL;
            end
         end
         ST_FS_REQ: st_d = ST_FS_WAIT;
         ST_FS_WAIT: begin
            if (rd_valid_i) begin
               fs_ld = 1'b1;
               st_d  = fs_ok ? ST_LEN_REQ : ST_STEP;
            end
         end
         ST_LEN_REQ: st_d = ST_LEN_WAIT;
         ST_LEN_WAIT: begin
            if (rd_valid_i) begin
               len_ld = 1'b1;
               st_d   = ST_STEP;
            end
         end
         ST_STEP: begin
            if (walk_last) begin
               st_d = ST_DONE;
            end else begin
               walk_adv = 1'b1;
               st_d     = ST_SIG_REQ;
            end
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign rd_req_o = (st_q == ST_SIG_REQ) || (st_q == ST_FS_REQ) || (st_q == ST_LEN_REQ);
   assign done_o   = (st_q == ST_DONE);

   always_comb begin
      unique case (st_q)
         ST_FS_REQ:  rd_addr_o = hdr_ofs + ADDR_W'(FS_FIELD_AT);
         ST_LEN_REQ: rd_addr_o = hdr_ofs + ADDR_W'(LEN_FIELD_AT);
         default:    rd_addr_o = walk_ofs;
      endcase
   end

endmodule

// File: rtl/fw_hdr_scan_chk.sv
module fw_hdr_scan_chk #(
   parameter int unsigned ADDR_W       = 24,
   parameter int unsigned FLASH_BYTES  = 32'h0002_0000,
   parameter int unsigned SECTOR_BYTES = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_valid_i,
   input logic              slice_valid_o,
   input logic [31:0]       slice_base_o,
   input logic [31:0]       slice_size_o,
   input logic              done_o
);

   logic pend_q;
   logic quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (rd_req_o) begin
         pend_q <= 1'b1;
      end else if (rd_valid_i) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= 1'b1;
      end else if (done_o) begin
         quiet_q <= 1'b1;
      end else if (start_i && quiet_q) begin
         quiet_q <= 1'b0;
      end
   end

   // R3: at most one read in flight
   a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> !pend_q);

   // R3: requests are single-cycle pulses
   a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);

   // R2: reads stay in the flash window
   a_r2_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (32'(rd_addr_o) < FLASH_BYTES));

   // R2: completion is a one-cycle pulse
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: an accepted slice base sits on a sector boundary
   a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      slice_valid_o |-> ((slice_base_o % SECTOR_BYTES) == 0));

   // R9: a start taken while idle clears the slice
   a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q && start_i) |=> (!slice_valid_o && slice_base_o == '0 && slice_size_o == '0));

   // R10: slice outputs hold between scans
   a_r10_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q && !start_i) |=> ($stable(slice_valid_o) && $stable(slice_base_o) && $stable(slice_size_o)));

endmodule

bind fw_hdr_scan fw_hdr_scan_chk #(
   .ADDR_W       (ADDR_W),
   .FLASH_BYTES  (FLASH_BYTES),
   .SECTOR_BYTES (SECTOR_BYTES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .rd_req_o      (rd_req_o),
   .rd_addr_o     (rd_addr_o),
   .rd_valid_i    (rd_valid_i),
   .slice_valid_o (slice_valid_o),
   .slice_base_o  (slice_base_o),
   .slice_size_o  (slice_size_o),
   .done_o        (done_o)
);

// File: tb/fw_hdr_scan_test.sv
module fw_hdr_scan_test;

   localparam int AW  = 24;
   localparam int FB  = 32'h8000;
   localparam int STR = 32'h1000;
   localparam logic [31:0] IMG  = 32'h3052_4448;
   localparam logic [31:0] BOOT = 32'h4346_4531;
   localparam logic [31:0] CFG  = 32'h4853_4C46;

   typedef struct packed {
      logic        v;
      logic [31:0] b;
      logic [31:0] s;
   } res_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_valid_i = 1'b0;
   logic [31:0]   rd_data_i = '0;
   logic          slice_valid_o;
   logic [31:0]   slice_base_o;
   logic [31:0]   slice_size_o;
   logic          done_o;

   logic [31:0]   mem [int];
   logic [AW-1:0] exp_addr [$];
   res_t          exp_res [$];
   int            n_chk = 0;
   int            n_bad = 0;
   int            done_cnt = 0;
   int            lat = 1;

   always #5 clk = ~clk;

   fw_hdr_scan #(
      .ADDR_W      (AW),
      .FLASH_BYTES (FB),
      .STRIDE_BYTES(STR)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .rd_req_o      (rd_req_o),
      .rd_addr_o     (rd_addr_o),
      .rd_valid_i    (rd_valid_i),
      .rd_data_i     (rd_data_i),
      .slice_valid_o (slice_valid_o),
      .slice_base_o  (slice_base_o),
      .slice_size_o  (slice_size_o),
      .done_o        (done_o)
   );

   function automatic logic [31:0] rdw(int a);
      return mem.exists(a) ? mem[a] : 32'hFFFF_FFFF;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // driver side of the scoreboard: expected reads and result from the requirements
   task automatic plan_scan();
      bit          seen = 0;
      res_t        r = '0;
      logic [31:0] f, l;
      for (int o = 0; o < FB; o += STR) begin
         exp_addr.push_back(AW'(o));
         if (rdw(o) == IMG && !seen) begin
            seen = 1;
            exp_addr.push_back(AW'(o + 24));
            f = rdw(o + 24);
            if (f[8:0] == 9'd0) begin
               exp_addr.push_back(AW'(o + 4));
               l   = rdw(o + 4);
               r.v = 1'b1;
               r.b = 32'(o) + f;
               r.s = l - f;
            end
         end
      end
      exp_res.push_back(r);
   endtask

   // flash responder
   initial begin
      logic [AW-1:0] a;
      forever begin
         @(negedge clk);
         rd_valid_i = 1'b0;
         if (rd_req_o) begin
            a = rd_addr_o;
            repeat (lat) @(negedge clk);
            rd_valid_i = 1'b1;
            rd_data_i  = rdw(int'(a));
         end
      end
   end

   // monitor side of the scoreboard
   initial begin
      logic [AW-1:0] e;
      res_t          r;
      forever begin
         @(negedge clk);
         if (rst_n && rd_req_o) begin
            if (exp_addr.size() == 0) begin
               chk(1'b0, "R3/R8 unexpected read", 64'(rd_addr_o), 64'hFFFF);
            end else begin
               e = exp_addr.pop_front();
               chk(rd_addr_o == e, "R2/R4 read address", 64'(rd_addr_o), 64'(e));
            end
         end
         if (rst_n && done_o) begin
            done_cnt++;
            chk(exp_addr.size() == 0, "R2 reads missing at done", 64'(exp_addr.size()), 64'd0);
            exp_addr.delete();
            if (exp_res.size() == 0) begin
               chk(1'b0, "R9 extra done pulse", 64'd1, 64'd0);
            end else begin
               r = exp_res.pop_front();
               chk(slice_valid_o == r.v, "R7 slice valid", 64'(slice_valid_o), 64'(r.v));
               chk(slice_base_o == r.b, "R7 slice base", 64'(slice_base_o), 64'(r.b));
               chk(slice_size_o == r.s, "R7 slice size", 64'(slice_size_o), 64'(r.s));
            end
         end
      end
   end

   task automatic run_scan(input bit mid_start, input bit chk_clear);
      int   d0 = done_cnt;
      logic sv;
      logic [31:0] sb, ss;
      plan_scan();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (chk_clear) begin
         chk(!slice_valid_o && slice_base_o == 0 && slice_size_o == 0, "R9 clear on start",
             64'(slice_base_o), 64'd0);
      end
      if (mid_start) begin
         repeat (6) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (done_cnt == d0) @(negedge clk);
      sv = slice_valid_o; sb = slice_base_o; ss = slice_size_o;
      repeat (8) @(negedge clk);
      chk(done_cnt == d0 + 1, "R2/R9 single done pulse", 64'(done_cnt - d0), 64'd1);
      chk(slice_valid_o == sv && slice_base_o == sb && slice_size_o == ss, "R10 hold after done",
          {slice_base_o, slice_size_o}, {sb, ss});
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!rd_req_o && !done_o && !slice_valid_o, "R1 reset controls",
          {61'd0, rd_req_o, done_o, slice_valid_o}, 64'd0);
      chk(slice_base_o == 0 && slice_size_o == 0, "R1 reset slice", {slice_base_o, slice_size_o}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 stray response while idle is ignored
      #1 rd_valid_i = 1'b1; rd_data_i = IMG;
      repeat (4) @(negedge clk);
      chk(!rd_req_o && !slice_valid_o && !done_o, "R3 stray valid ignored",
          {62'd0, rd_req_o, slice_valid_o}, 64'd0);

      // R2/R5 blank flash
      lat = 1;
      mem.delete();
      run_scan(0, 0);

      // R4/R7/R5 header with neighbouring boot and config signatures
      lat = 2;
      mem.delete();
      mem[32'h0000] = BOOT;
      mem[32'h7000] = CFG;
      mem[32'h2000] = IMG;
      mem[32'h2004] = 32'h0001_0000;
      mem[32'h2018] = 32'h0000_0400;
      run_scan(0, 0);

      // R6/R8/R9 misaligned first header, aligned later header ignored; start clears old slice
      lat = 3;
      mem.delete();
      mem[32'h1000] = IMG;
      mem[32'h1004] = 32'h0000_8000;
      mem[32'h1018] = 32'h0000_0104;
      mem[32'h3000] = IMG;
      mem[32'h3004] = 32'h0000_4000;
      mem[32'h3018] = 32'h0000_0200;
      run_scan(0, 1);

      // R8 two aligned headers: first wins
      lat = 1;
      mem.delete();
      mem[32'h5000] = IMG;
      mem[32'h5004] = 32'h0000_1000;
      mem[32'h5018] = 32'h0000_0200;
      mem[32'h6000] = IMG;
      mem[32'h6004] = 32'h0000_9000;
      mem[32'h6018] = 32'h0000_0400;
      run_scan(0, 0);

      // R2/R7 header at last position, length below offset wraps
      lat = 2;
      mem.delete();
      mem[32'h7000] = IMG;
      mem[32'h7004] = 32'h0000_0100;
      mem[32'h7018] = 32'h0000_0200;
      run_scan(0, 1);

      // R9 start pulse during a scan is ignored
      lat = 1;
      mem.delete();
      mem[32'h2000] = IMG;
      mem[32'h2004] = 32'h0000_3000;
      mem[32'h2018] = 32'h0000_0000;
      run_scan(1, 1);

      summary();
      $finish;
   end

endmodule